// File: doc/BRIEF.md
# Microword Field Patch and Parity Regenerator

This unit rewrites one control-store word that arrives as three 16-bit slices. It places a new 8-bit function value into two 4-bit fields of the word. The high nibble goes into the first slice and the low nibble into the second. It then regenerates the word's single parity bit, and returns the three slices ready to be written back. The parity bit sits inside the second slice. It is corrected by XOR, so the old parity bit takes part in the computation.

Parity covers the first two slices in full and the top 4 bits of the third slice. The remaining 12 bits of the third slice are carried through and never enter the parity. The unit works in steps: capture, merge the fields, four fold cycles that halve the 16-bit parity word, and write-out. The first-slice field occupies bits [3:0]. The second-slice field occupies bits [13:10]. The parity bit is bit 0 of the second slice.

A caller waits for `ready_o`, pulses `start_i` with the slices and the function value, and takes the patched slices when `done_o` pulses.

Top module: `mwp_patch_parity`

## Requirements
- R1: After reset `done_o` is 0, `ready_o` is 1 and all three slice outputs are 0.
- R2: `slice0_o` equals `slice0_i` with bits [3:0] replaced by `func_i[7:4]`. Old field bits are cleared before the merge, not ORed with the new ones.
- R3: `slice1_o` bits [15:14] and [9:1] equal `slice1_i`. Bits [13:10] equal `func_i[3:0]`, again with the old field cleared first.
- R4: `slice2_o` equals `slice2_i` unchanged.
- R5: `slice1_o[0]` equals `slice1_i[0]` XOR NOT(XOR-reduction of m0 ^ m1 ^ {12'b0, slice2_i[15:12]}). Here m0 and m1 are the two slices after the field merge, with the old bit 0 still present. As a result, the 36 bits {slice0_o, slice1_o, slice2_o[15:12]} have odd parity.
- R6: `slice2_i[11:0]` has no effect on `slice1_o`.
- R7: `start_i` is accepted only while `ready_o` is 1. `ready_o` is 0 from the accepting edge until the result is written. `done_o` is a one-cycle pulse, high in the cycle after the 6th rising edge counted from the accepting edge (one merge cycle, four fold cycles, one write cycle).
- R8: A `start_i` that arrives while `ready_o` is 0 is ignored, and its data is not sampled. The slice outputs change only when `done_o` rises, and hold their values between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; inputs sampled when accepted |
| ready_o | output | 1 | Unit idle and able to accept a start |
| slice0_i | input | 16 | First slice of the word (holds field A) |
| slice1_i | input | 16 | Second slice (holds field B and the parity bit) |
| slice2_i | input | 16 | Third slice; top 4 bits enter parity |
| func_i | input | 8 | New function value: [7:4] to field A, [3:0] to field B |
| slice0_o | output | 16 | Patched first slice |
| slice1_o | output | 16 | Patched second slice with corrected parity |
| slice2_o | output | 16 | Third slice, passed through |
| done_o | output | 1 | One-cycle pulse: patched slices valid |

## Verification
The hardest situation to reach is a second start that arrives mid-job with different data. Sampling it would corrupt the running result or launch a stray job. The bench holds `start_i` high with new slices through every busy cycle of a job, drops it just before the write edge, and then checks that the result belongs to the first job and that no further `done_o` appears. Every value of the function byte is also swept against several slice patterns. These include old fields that are all ones, which expose an OR without clearing, and pairs of third-slice words that differ only in their low 12 bits.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MERGE = 2'd1,
    ST_FOLD  = 2'd2,
    ST_WRITE = 2'd3
  } mwp_state_e;
endpackage

// File: rtl/mwp_field_merge.sv
module mwp_field_merge #(
  parameter int W   = 16,
  parameter int FW  = 4,
  parameter int LSB = 0
) (
  input  logic [W-1:0]  word_i,
  input  logic [FW-1:0] field_i,
  output logic [W-1:0]  word_o
);
  localparam logic [W-1:0] MASK = {{(W-FW){1'b0}}, {FW{1'b1}}} << LSB;

  logic [W-1:0] field_w;
  assign field_w = {{(W-FW){1'b0}}, field_i} << LSB;
  // clear first, then merge
  assign word_o  = (word_i & ~MASK) | field_w;
endmodule

// File: rtl/mwp_parity_fold.sv
module mwp_parity_fold #(
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [W-1:0]         data_i,
  input  logic                 fold_i,
  input  logic [((W>2)?$clog2($clog2(W)):1)-1:0] idx_i,
  output logic                 par_o
);
  localparam int S = $clog2(W);

  logic [W-1:0] acc_q;
  logic [W-1:0] cand [S];

  for (genvar k = 0; k < S; k++) begin : g_stage
    localparam int H = W >> (k + 1);
    assign cand[k] = {{(W-H){1'b0}}, acc_q[2*H-1:H] ^ acc_q[H-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= data_i;
    else if (fold_i) acc_q <= cand[idx_i];
  end

  // complemented final fold: odd overall parity
  assign par_o = ~acc_q[0];
endmodule

// File: rtl/mwp_ctrl.sv
module mwp_ctrl
  import mwp_pkg::*;
#(
  parameter int FOLDS = 4,
  parameter int IW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          ready_o,
  output logic          capture_o,
  output logic          merge_o,
  output logic          fold_o,
  output logic [IW-1:0] idx_o,
  output logic          write_o
);
  localparam logic [IW-1:0] LAST = IW'(FOLDS - 1);

  mwp_state_e   state_q;
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_MERGE;
        ST_MERGE: begin
          state_q <= ST_FOLD;
          cnt_q   <= '0;
        end
        ST_FOLD: begin
          if (cnt_q == LAST) state_q <= ST_WRITE;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign capture_o = ready_o && start_i;
  assign merge_o   = (state_q == ST_MERGE);
  assign fold_o    = (state_q == ST_FOLD);
  assign idx_o     = cnt_q;
  assign write_o   = (state_q == ST_WRITE);
endmodule

// File: rtl/mwp_patch_parity.sv
module mwp_patch_parity #(
  parameter int SLICE_W = 16,
  parameter int FN_W    = 4,
  parameter int FA_LSB  = 0,
  parameter int FB_LSB  = 10,
  parameter int PAR_BIT = 0,
  parameter int TAG_W   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 ready_o,
  input  logic [SLICE_W-1:0]   slice0_i,
  input  logic [SLICE_W-1:0]   slice1_i,
  input  logic [SLICE_W-1:0]   slice2_i,
  input  logic [2*FN_W-1:0]    func_i,
  output logic [SLICE_W-1:0]   slice0_o,
  output logic [SLICE_W-1:0]   slice1_o,
  output logic [SLICE_W-1:0]   slice2_o,
  output logic                 done_o
);
  localparam int FOLDS = $clog2(SLICE_W);
  localparam int IW    = (SLICE_W > 2) ? $clog2(FOLDS) : 1;

  logic [SLICE_W-1:0] s0_q, s1_q, s2_q;
  logic [2*FN_W-1:0]  fn_q;
  logic [SLICE_W-1:0] m0, m1, pword, par_w;
  logic               capture, merge, fold, write, par;
  logic [IW-1:0]      idx;

  mwp_ctrl #(.FOLDS(FOLDS), .IW(IW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .ready_o   (ready_o),
    .capture_o (capture),
    .merge_o   (merge),
    .fold_o    (fold),
    .idx_o     (idx),
    .write_o   (write)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q <= '0;
      s1_q <= '0;
      s2_q <= '0;
      fn_q <= '0;
    end else if (capture) begin
      s0_q <= slice0_i;
      s1_q <= slice1_i;
      s2_q <= slice2_i;
      fn_q <= func_i;
    end
  end

  mwp_field_merge #(.W(SLICE_W), .FW(FN_W), .LSB(FA_LSB)) u_merge_a (
    .word_i  (s0_q),
    .field_i (fn_q[2*FN_W-1:FN_W]),
    .word_o  (m0)
  );

  mwp_field_merge #(.W(SLICE_W), .FW(FN_W), .LSB(FB_LSB)) u_merge_b (
    .word_i  (s1_q),
    .field_i (fn_q[FN_W-1:0]),
    .word_o  (m1)
  );

  // third slice: only its top bits, right-aligned
  assign pword = m0 ^ m1 ^ {{(SLICE_W-TAG_W){1'b0}}, s2_q[SLICE_W-1 -: TAG_W]};

  mwp_parity_fold #(.W(SLICE_W)) u_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (merge),
    .data_i (pword),
    .fold_i (fold),
    .idx_i  (idx),
    .par_o  (par)
  );

  assign par_w = {{(SLICE_W-1){1'b0}}, par} << PAR_BIT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slice0_o <= '0;
      slice1_o <= '0;
      slice2_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= write;
      if (write) begin
        slice0_o <= m0;
        slice1_o <= m1 ^ par_w;
        slice2_o <= s2_q;
      end
    end
  end
endmodule

// File: rtl/mwp_patch_parity_chk.sv
module mwp_patch_parity_chk #(
  parameter int SLICE_W = 16,
  parameter int TAG_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               ready_o,
  input logic [SLICE_W-1:0] slice0_o,
  input logic [SLICE_W-1:0] slice1_o,
  input logic [SLICE_W-1:0] slice2_o,
  input logic               done_o
);
  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7: an accepted start makes the unit busy
  a_r7_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

  // R7: done only follows a busy cycle
  a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!ready_o));

  // R5: written word has odd parity over the covered bits
  a_r5_odd_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (^{slice0_o, slice1_o, slice2_o[SLICE_W-1 -: TAG_W]}) == 1'b1);

  // R8: outputs hold between results
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(slice0_o) && $stable(slice1_o) && $stable(slice2_o)));
endmodule

bind mwp_patch_parity mwp_patch_parity_chk #(.SLICE_W(SLICE_W), .TAG_W(TAG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .ready_o  (ready_o),
  .slice0_o (slice0_o),
  .slice1_o (slice1_o),
  .slice2_o (slice2_o),
  .done_o   (done_o)
);

// File: tb/mwp_patch_parity_bench.sv
`timescale 1ns/1ps
module mwp_patch_parity_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ready;
  logic [15:0] s0_i = '0, s1_i = '0, s2_i = '0;
  logic [7:0]  fn_i = '0;
  logic [15:0] s0_o, s1_o, s2_o;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mwp_patch_parity u_mwp_patch_parity (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .ready_o  (ready),
    .slice0_i (s0_i),
    .slice1_i (s1_i),
    .slice2_i (s2_i),
    .func_i   (fn_i),
    .slice0_o (s0_o),
    .slice1_o (s1_o),
    .slice2_o (s2_o),
    .done_o   (done)
  );

  function automatic logic [15:0] exp0(input logic [15:0] a, input logic [7:0] f);
    return (a & 16'hFFF0) | {12'h000, f[7:4]};
  endfunction

  function automatic logic [15:0] exp1(input logic [15:0] a, input logic [15:0] b,
                                       input logic [15:0] c, input logic [7:0] f);
    logic [15:0] m0, m1, x;
    logic p;
    m0 = exp0(a, f);
    m1 = (b & 16'hC3FF) | ({12'h000, f[3:0]} << 10);
    x  = m0 ^ m1 ^ {12'h000, c[15:12]};
    p  = ~(^x);
    return m1 ^ {15'h0000, p};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // returns at the negedge after done should have risen
  task automatic run_job(input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] c, input logic [7:0] f, input bit tm);
    @(negedge clk);
    s0_i = a; s1_i = b; s2_i = c; fn_i = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (tm) chk("R7 ready low after accept", {15'd0, ready}, 16'd0);
    repeat (5) @(negedge clk);
    if (tm) chk("R7 done not early", {15'd0, done}, 16'd0);
    @(negedge clk);
    chk("R7 done pulse", {15'd0, done}, 16'd1);
    chk("R2 slice0", s0_o, exp0(a, f));
    chk("R3/R5 slice1", s1_o, exp1(a, b, c, f));
    chk("R4 slice2", s2_o, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held0, held1, held2, r6_a;
    logic [15:0] pa [4];
    logic [15:0] pb [4];
    logic [15:0] pc [4];
    pa[0] = 16'h0000; pb[0] = 16'h0000; pc[0] = 16'h0000;
    pa[1] = 16'hFFFF; pb[1] = 16'hFFFF; pc[1] = 16'hFFFF;
    pa[2] = 16'hA5A5; pb[2] = 16'h5A5A; pc[2] = 16'h3C00;
    pa[3] = 16'h1234; pb[3] = 16'hFEDC; pc[3] = 16'h9876;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 ready", {15'd0, ready}, 16'd1);
    chk("R1 slice0", s0_o, 16'd0);
    chk("R1 slice1", s1_o, 16'd0);
    chk("R1 slice2", s2_o, 16'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R7: full sweep of the function byte over patterns
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 256; f++) begin
        run_job(pa[p] ^ 16'(f * 37), pb[p] ^ 16'(f * 911), pc[p] ^ 16'(f << 4),
                8'(f), (f % 64) == 0);
        checks++;
        if ((^{s0_o, s1_o, s2_o[15:12]}) !== 1'b1) begin
          fails++;
          $display("FAIL R5 odd parity: actual even expected odd");
        end
      end
    end

    // R6: low 12 bits of slice2 do not reach the parity bit
    run_job(16'h0F0F, 16'h7001, 16'hB000, 8'h3C, 1'b0);
    r6_a = s1_o;
    run_job(16'h0F0F, 16'h7001, 16'hBFFF, 8'h3C, 1'b0);
    chk("R6 slice1 independent of slice2 low bits", s1_o, r6_a);
    run_job(16'h0F0F, 16'h7001, 16'hB5A3, 8'h3C, 1'b0);
    chk("R6 slice1 independent of slice2 low bits", s1_o, r6_a);

    // R8: start held high with other data during a busy job
    @(negedge clk);
    s0_i = 16'h1357; s1_i = 16'h2468; s2_i = 16'hC0DE; fn_i = 8'h9B; start = 1'b1;
    @(negedge clk);
    s0_i = 16'hDEAD; s1_i = 16'hBEEF; s2_i = 16'h4321; fn_i = 8'h66;
    repeat (5) @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R8 done for first job", {15'd0, done}, 16'd1);
    chk("R8 slice0 from first job", s0_o, exp0(16'h1357, 8'h9B));
    chk("R8 slice1 from first job", s1_o, exp1(16'h1357, 16'h2468, 16'hC0DE, 8'h9B));
    chk("R8 slice2 from first job", s2_o, 16'hC0DE);
    held0 = s0_o; held1 = s1_o; held2 = s2_o;
    // R8: no stray job and outputs hold while inputs move
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      s0_i = 16'(i * 4099); s1_i = ~16'(i); s2_i = 16'(i << 12); fn_i = 8'(i * 17);
      chk("R8 no stray done", {15'd0, done}, 16'd0);
    end
    chk("R8 slice0 held", s0_o, held0);
    chk("R8 slice1 held", s1_o, held1);
    chk("R8 slice2 held", s2_o, held2);
    chk("R7 ready when idle", {15'd0, ready}, 16'd1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule